// File: doc/BRIEF.md
# Rail Reference Soft-Start Sequencer

This block steers the reference code that a voltage-reference DAC receives for one power rail. It handles the rail's turn-on and turn-off. When the enable request rises, the block first counts a programmable turn-on delay. It then slews the reference upward from zero, which makes the regulated output follow under closed-loop control. The ramp lasts a programmable number of cycles and ends exactly on the commanded code. The block then holds that code. When enable falls, it counts an off delay and slews the reference back down to zero.

The per-cycle increment is the commanded code divided by the rise time. It is computed once, as a fixed-point value with 16 fractional bits. A fractional accumulator carries the remainder, so the rounding error never grows past one code. A tracking input can replace the block's own ramp with another rail's reference code. A two-bit mode output tells the compensator which coefficient set to use: off, ramping, regulating, or regulating at light load. All configuration arrives as already-decoded values, and the time unit is one clock cycle.

Top module: `rail_ref_sequencer`

## Requirements
- R1: After reset, `ref_code_o` is 0, `mode_o` is 0 (off) and `pgood_o` is 0.
- R2: The cycle that samples `en_i` high in idle starts the turn-on delay. `mode_o` then stays 0 and `ref_code_o` stays 0 for `on_delay_i`+1 cycles after that edge. On the next edge the ramp begins and `mode_o` becomes 1. If `en_i` falls during the delay, the block returns to idle without ramping.
- R3: Let N = max(`rise_time_i`,1) and S = floor(T·65536/N), where T is the latched target. After k ramp-up edges with k < N, `ref_code_o` equals floor(k·S/65536).
- R4: On the N-th ramp-up edge `ref_code_o` becomes exactly T and `pgood_o` is high for that single cycle. `ref_code_o` never exceeds T.
- R5: The `mode_o` encoding is: 0 = idle or turn-on delay, 1 = ramp up or ramp down, 2 = regulate or off delay, 3 = regulate or off delay while `light_load_i` is high.
- R6: `target_code_i` is latched on the edge that accepts enable. Any change to it later in the sequence leaves the final code unchanged.
- R7: When `en_i` falls in regulation, `ref_code_o` holds for `off_delay_i`+1 cycles. The ramp down then starts. Let M = max(`fall_time_i`,1) and D = floor(C/M), where C is the starting accumulator value (code·65536). After j ramp-down edges the code is floor((C−j·D)/65536). After M edges it is 0 and `mode_o` is 0.
- R8: If `en_i` falls during the ramp up, the next edge starts the ramp down directly from the current accumulator value, using the R7 step.
- R9: `en_i` rising during the off delay or the ramp down has no effect. The ramp down still starts and still reaches 0.
- R10: While `track_en_i` is high during a ramp, each edge loads `ref_code_o` with min(`track_code_i`, T). The ramp up ends, with the `pgood_o` pulse, once `track_code_i` ≥ T. The ramp down ends in idle once `track_code_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Rail enable request |
| target_code_i | input | CODE_W | Commanded reference code |
| on_delay_i | input | TIME_W | Turn-on delay in cycles |
| rise_time_i | input | TIME_W | Ramp-up length in cycles |
| off_delay_i | input | TIME_W | Turn-off delay in cycles |
| fall_time_i | input | TIME_W | Ramp-down length in cycles |
| track_en_i | input | 1 | Follow `track_code_i` instead of the own ramp |
| track_code_i | input | CODE_W | Reference code of the followed rail |
| light_load_i | input | 1 | Light-load indication from the power stage |
| ref_code_o | output | CODE_W | Reference DAC code |
| mode_o | output | 2 | Operating mode for selecting compensation |
| pgood_o | output | 1 | One-cycle pulse when the ramp up completes |

## Verification
All three outputs come straight from registers; `mode_o` also depends on `light_load_i` without any delay. Each result is therefore due at a known clock edge. Counted from the edge that accepts enable, the ramp mode appears at edge `on_delay_i`+2. The k-th ramp code follows k edges after that, and the target and power-good pulse arrive N edges after the ramp starts. The turn-off sequence has matching counts, starting from the edge that sees enable low. The bench advances by exact edge counts derived from these rules and samples 1 ns after an edge. It checks intermediate codes against the fixed-point formula, not merely the end points.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE      = 3'd0,
        SQ_ON_WAIT   = 3'd1,
        SQ_RISE      = 3'd2,
        SQ_HOLD      = 3'd3,
        SQ_OFF_WAIT  = 3'd4,
        SQ_FALL      = 3'd5
    } rseq_state_e;

    typedef enum logic [1:0] {
        MD_OFF   = 2'd0,
        MD_RAMP  = 2'd1,
        MD_REG   = 2'd2,
        MD_LIGHT = 2'd3
    } rseq_mode_e;

    typedef enum logic [2:0] {
        AOP_KEEP   = 3'd0,
        AOP_INC    = 3'd1,
        AOP_DEC    = 3'd2,
        AOP_TARGET = 3'd3,
        AOP_FOLLOW = 3'd4,
        AOP_ZERO   = 3'd5
    } rseq_acc_op_e;

    typedef enum logic [1:0] {
        TSEL_ON   = 2'd0,
        TSEL_RISE = 2'd1,
        TSEL_OFF  = 2'd2,
        TSEL_FALL = 2'd3
    } rseq_tsel_e;

    // Control word from the sequencing FSM to the datapath
    typedef struct packed {
        rseq_acc_op_e op;
        logic         step_ld;
        logic         step_from_acc;
        logic         den_fall;
        logic         tmr_ld;
        rseq_tsel_e   tmr_sel;
        logic         tmr_dec;
        logic         tgt_ld;
    } rseq_ctrl_t;

    function automatic rseq_mode_e mode_of(rseq_state_e st, logic light);
        case (st)
            SQ_RISE, SQ_FALL:     mode_of = MD_RAMP;
            SQ_HOLD, SQ_OFF_WAIT: mode_of = light ? MD_LIGHT : MD_REG;
            default:              mode_of = MD_OFF;
        endcase
    endfunction

endpackage

// File: rtl/rseq_timer.sv
module rseq_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rseq_ramp_acc.sv
module rseq_ramp_acc
    import rseq_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int FRAC_W = 16,
    parameter int TIME_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  rseq_acc_op_e      op_i,
    input  logic              step_ld_i,
    input  logic              step_from_acc_i,
    input  logic [CODE_W-1:0] new_tgt_i,
    input  logic [TIME_W-1:0] den_i,
    input  logic [CODE_W-1:0] tgt_i,
    input  logic [CODE_W-1:0] follow_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int ACC_W = CODE_W + FRAC_W;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  step_q;
    logic [ACC_W-1:0]  num_w;
    logic [TIME_W-1:0] den_nz_w;
    logic [ACC_W-1:0]  quot_w;

    // One divide per sequence phase: span / length, length of zero treated as one
    always_comb begin
        num_w    = step_from_acc_i ? acc_q : {new_tgt_i, {FRAC_W{1'b0}}};
        den_nz_w = (den_i == '0) ? TIME_W'(1) : den_i;
        quot_w   = num_w / ACC_W'(den_nz_w);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q  <= '0;
            step_q <= '0;
        end else begin
            if (step_ld_i) begin
                step_q <= quot_w;
            end
            case (op_i)
                AOP_INC:    acc_q <= acc_q + step_q;
                AOP_DEC:    acc_q <= (acc_q >= step_q) ? acc_q - step_q : '0;
                AOP_TARGET: acc_q <= {tgt_i, {FRAC_W{1'b0}}};
                AOP_FOLLOW: acc_q <= {follow_i, {FRAC_W{1'b0}}};
                AOP_ZERO:   acc_q <= '0;
                default:    acc_q <= acc_q;
            endcase
        end
    end

    assign code_o = acc_q[ACC_W-1 -: CODE_W];
endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
    import rseq_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        en_i,
    input  logic        track_en_i,
    input  logic        trk_reached_i,
    input  logic        trk_zero_i,
    input  logic        tmr_zero_i,
    input  logic        light_i,
    output rseq_state_e state_o,
    output rseq_ctrl_t  ctl_o,
    output rseq_mode_e  mode_o,
    output logic        pgood_o
);
    rseq_state_e st_q, st_d;
    logic        pg_q, pg_set;

    always_comb begin
        st_d   = st_q;
        pg_set = 1'b0;
        ctl_o  = '{op: AOP_KEEP, step_ld: 1'b0, step_from_acc: 1'b0,
                   den_fall: 1'b0, tmr_ld: 1'b0, tmr_sel: TSEL_ON,
                   tmr_dec: 1'b0, tgt_ld: 1'b0};
        case (st_q)
            SQ_IDLE: begin
                if (en_i) begin
                    st_d          = SQ_ON_WAIT;
                    ctl_o.tmr_ld  = 1'b1;
                    ctl_o.tmr_sel = TSEL_ON;
                    ctl_o.step_ld = 1'b1;
                    ctl_o.tgt_ld  = 1'b1;
                end
            end
            SQ_ON_WAIT: begin
                if (!en_i) begin
                    st_d = SQ_IDLE;
                end else if (tmr_zero_i) begin
                    st_d          = SQ_RISE;
                    ctl_o.tmr_ld  = 1'b1;
                    ctl_o.tmr_sel = TSEL_RISE;
                end else begin
                    ctl_o.tmr_dec = 1'b1;
                end
            end
            SQ_RISE: begin
                if (!en_i) begin
                    st_d                = SQ_FALL;
                    ctl_o.step_ld       = 1'b1;
                    ctl_o.step_from_acc = 1'b1;
                    ctl_o.den_fall      = 1'b1;
                    ctl_o.tmr_ld        = 1'b1;
                    ctl_o.tmr_sel       = TSEL_FALL;
                end else if (track_en_i) begin
                    ctl_o.op = AOP_FOLLOW;
                    if (trk_reached_i) begin
                        st_d   = SQ_HOLD;
                        pg_set = 1'b1;
                    end
                end else if (tmr_zero_i) begin
                    ctl_o.op = AOP_TARGET;
                    st_d     = SQ_HOLD;
                    pg_set   = 1'b1;
                end else begin
                    ctl_o.op      = AOP_INC;
                    ctl_o.tmr_dec = 1'b1;
                end
            end
            SQ_HOLD: begin
                if (!en_i) begin
                    st_d          = SQ_OFF_WAIT;
                    ctl_o.tmr_ld  = 1'b1;
                    ctl_o.tmr_sel = TSEL_OFF;
                end
            end
            SQ_OFF_WAIT: begin
                if (tmr_zero_i) begin
                    st_d                = SQ_FALL;
                    ctl_o.step_ld       = 1'b1;
                    ctl_o.step_from_acc = 1'b1;
                    ctl_o.den_fall      = 1'b1;
                    ctl_o.tmr_ld        = 1'b1;
                    ctl_o.tmr_sel       = TSEL_FALL;
                end else begin
                    ctl_o.tmr_dec = 1'b1;
                end
            end
            SQ_FALL: begin
                if (track_en_i) begin
                    ctl_o.op = AOP_FOLLOW;
                    if (trk_zero_i) begin
                        st_d = SQ_IDLE;
                    end
                end else if (tmr_zero_i) begin
                    ctl_o.op = AOP_ZERO;
                    st_d     = SQ_IDLE;
                end else begin
                    ctl_o.op      = AOP_DEC;
                    ctl_o.tmr_dec = 1'b1;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= SQ_IDLE;
            pg_q <= 1'b0;
        end else begin
            st_q <= st_d;
            pg_q <= pg_set;
        end
    end

    assign state_o = st_q;
    assign pgood_o = pg_q;
    assign mode_o  = mode_of(st_q, light_i);
endmodule

// File: rtl/rail_ref_sequencer.sv
module rail_ref_sequencer
    import rseq_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int TIME_W = 16,
    parameter int FRAC_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [CODE_W-1:0] target_code_i,
    input  logic [TIME_W-1:0] on_delay_i,
    input  logic [TIME_W-1:0] rise_time_i,
    input  logic [TIME_W-1:0] off_delay_i,
    input  logic [TIME_W-1:0] fall_time_i,
    input  logic              track_en_i,
    input  logic [CODE_W-1:0] track_code_i,
    input  logic              light_load_i,
    output logic [CODE_W-1:0] ref_code_o,
    output logic [1:0]        mode_o,
    output logic              pgood_o
);
    rseq_state_e       state_w;
    rseq_ctrl_t        ctl_w;
    rseq_mode_e        mode_w;
    logic              tmr_zero_w;
    logic [TIME_W-1:0] tmr_val_w;
    logic [TIME_W-1:0] den_w;
    logic [CODE_W-1:0] tgt_q;
    logic [CODE_W-1:0] follow_w;
    logic              trk_reached_w;
    logic              trk_zero_w;

    function automatic logic [TIME_W-1:0] last_idx(logic [TIME_W-1:0] len);
        last_idx = (len == '0) ? '0 : len - TIME_W'(1);
    endfunction

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tgt_q <= '0;
        end else if (ctl_w.tgt_ld) begin
            tgt_q <= target_code_i;
        end
    end

    always_comb begin
        case (ctl_w.tmr_sel)
            TSEL_ON:   tmr_val_w = on_delay_i;
            TSEL_RISE: tmr_val_w = last_idx(rise_time_i);
            TSEL_OFF:  tmr_val_w = off_delay_i;
            default:   tmr_val_w = last_idx(fall_time_i);
        endcase
        den_w         = ctl_w.den_fall ? fall_time_i : rise_time_i;
        follow_w      = (track_code_i < tgt_q) ? track_code_i : tgt_q;
        trk_reached_w = (track_code_i >= tgt_q);
        trk_zero_w    = (track_code_i == '0);
    end

    rseq_ctrl u_ctrl (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .en_i          (en_i),
        .track_en_i    (track_en_i),
        .trk_reached_i (trk_reached_w),
        .trk_zero_i    (trk_zero_w),
        .tmr_zero_i    (tmr_zero_w),
        .light_i       (light_load_i),
        .state_o       (state_w),
        .ctl_o         (ctl_w),
        .mode_o        (mode_w),
        .pgood_o       (pgood_o)
    );

    rseq_timer #(.W(TIME_W)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .ld_i     (ctl_w.tmr_ld),
        .ld_val_i (tmr_val_w),
        .dec_i    (ctl_w.tmr_dec),
        .zero_o   (tmr_zero_w)
    );

    rseq_ramp_acc #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .TIME_W(TIME_W)) u_acc (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .op_i            (ctl_w.op),
        .step_ld_i       (ctl_w.step_ld),
        .step_from_acc_i (ctl_w.step_from_acc),
        .new_tgt_i       (target_code_i),
        .den_i           (den_w),
        .tgt_i           (tgt_q),
        .follow_i        (follow_w),
        .code_o          (ref_code_o)
    );

    assign mode_o = mode_w;
endmodule

// File: rtl/rseq_checker.sv
module rseq_checker
    import rseq_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input logic              clk_i,
    input logic              rst_i,
    input rseq_state_e       state_i,
    input logic [CODE_W-1:0] ref_i,
    input logic [1:0]        mode_i,
    input logic              pgood_i,
    input logic [CODE_W-1:0] tgt_i,
    input logic              track_en_i
);
    a_r1_idle_ref_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == SQ_IDLE) |-> (ref_i == '0));

    a_r3_rise_monotonic: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == SQ_RISE && $past(state_i) == SQ_RISE && !track_en_i && !$past(track_en_i))
        |-> (ref_i >= $past(ref_i)));

    a_r4_no_overshoot: assert property (@(posedge clk_i) disable iff (rst_i)
        ref_i <= tgt_i);

    a_r4_pgood_at_target: assert property (@(posedge clk_i) disable iff (rst_i)
        pgood_i |-> (ref_i == tgt_i && state_i == SQ_HOLD));

    a_r4_pgood_single: assert property (@(posedge clk_i) disable iff (rst_i)
        pgood_i |=> !pgood_i);

    a_r5_ramp_mode: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == SQ_RISE || state_i == SQ_FALL) |-> (mode_i == 2'd1));

    a_r7_fall_monotonic: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == SQ_FALL && $past(state_i) == SQ_FALL && !track_en_i && !$past(track_en_i))
        |-> (ref_i <= $past(ref_i)));
endmodule

bind rail_ref_sequencer rseq_checker #(.CODE_W(CODE_W)) u_rseq_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .state_i    (state_w),
    .ref_i      (ref_code_o),
    .mode_i     (mode_o),
    .pgood_i    (pgood_o),
    .tgt_i      (tgt_q),
    .track_en_i (track_en_i)
);

// File: tb/rail_ref_sequencer_tb_top.sv
`timescale 1ns/1ps
module rail_ref_sequencer_tb_top;
    localparam int CODE_W = 12;
    localparam int TIME_W = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              en;
    logic [CODE_W-1:0] tgt;
    logic [TIME_W-1:0] on_d, rise_t, off_d, fall_t;
    logic              trk_en;
    logic [CODE_W-1:0] trk_code;
    logic              light;
    logic [CODE_W-1:0] ref_code;
    logic [1:0]        mode;
    logic              pgood;

    int nvec = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    rail_ref_sequencer #(.CODE_W(CODE_W), .TIME_W(TIME_W)) dut_i (
        .clk_i(clk), .rst_i(rst), .en_i(en), .target_code_i(tgt),
        .on_delay_i(on_d), .rise_time_i(rise_t), .off_delay_i(off_d),
        .fall_time_i(fall_t), .track_en_i(trk_en), .track_code_i(trk_code),
        .light_load_i(light), .ref_code_o(ref_code), .mode_o(mode), .pgood_o(pgood)
    );

    task automatic chk(string req, longint act, longint exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic adv(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic longint up_code(int t, int n, int k);
        longint s = (longint'(t) << 16) / ((n == 0) ? 1 : n);
        return (longint'(k) * s) >> 16;
    endfunction

    function automatic longint dn_code(longint c, int m, int j);
        longint s = c / ((m == 0) ? 1 : m);
        return (c - longint'(j) * s) >> 16;
    endfunction

    // Start from idle, run to regulation while checking each cycle
    task automatic rise_seq(int t, int d, int n, bit chg_tgt);
        tgt = t[CODE_W-1:0]; on_d = d[TIME_W-1:0]; rise_t = n[TIME_W-1:0];
        en = 1'b1;
        adv(1);
        chk("R2 mode in delay", mode, 0);
        adv(d);
        chk("R2 ref at delay end", ref_code, 0);
        chk("R2 mode at delay end", mode, 0);
        if (chg_tgt) tgt = 12'd3000;
        adv(1);
        chk("R2 ramp mode start", mode, 1);
        chk("R2 ref at ramp start", ref_code, 0);
        for (int k = 1; k < ((n == 0) ? 1 : n); k++) begin
            adv(1);
            chk("R3 ramp code", ref_code, up_code(t, n, k));
            chk("R4 no early pgood", pgood, 0);
        end
        adv(1);
        chk("R4 final code exact", ref_code, t);
        chk("R4 pgood pulse", pgood, 1);
        chk("R5 regulate mode", mode, 2);
        adv(1);
        chk("R4 pgood one cycle", pgood, 0);
    endtask

    task automatic fall_seq(int t, int d, int m);
        off_d = d[TIME_W-1:0]; fall_t = m[TIME_W-1:0];
        en = 1'b0;
        adv(1);
        chk("R7 hold in off delay", ref_code, t);
        chk("R5 off delay mode", mode, 2);
        adv(d);
        chk("R7 hold at off delay end", ref_code, t);
        adv(1);
        chk("R7 fall mode", mode, 1);
        for (int j = 1; j < ((m == 0) ? 1 : m); j++) begin
            adv(1);
            chk("R7 fall code", ref_code, dn_code(longint'(t) << 16, m, j));
        end
        adv(1);
        chk("R7 reaches zero", ref_code, 0);
        chk("R7 idle mode", mode, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b0; tgt = '0; on_d = '0; rise_t = '0; off_d = '0;
        fall_t = '0; trk_en = 1'b0; trk_code = '0; light = 1'b0;
        adv(3);
        rst = 1'b0;
        adv(1);
        chk("R1 ref after reset", ref_code, 0);
        chk("R1 mode after reset", mode, 0);
        chk("R1 pgood after reset", pgood, 0);
    endtask

    task automatic t_basic_cycle();
        rise_seq(1000, 3, 7, 1'b0);
        light = 1'b1; #1;
        chk("R5 light load mode", mode, 3);
        light = 1'b0; #1;
        chk("R5 back to regulate", mode, 2);
        fall_seq(1000, 2, 5);
    endtask

    task automatic t_target_latched();
        rise_seq(700, 1, 4, 1'b1);
        chk("R6 target change ignored", ref_code, 700);
        fall_seq(700, 0, 3);
    endtask

    task automatic t_zero_rise();
        rise_seq(4095, 0, 0, 1'b0);
        fall_seq(4095, 1, 0);
    endtask

    task automatic t_abort_on_delay();
        tgt = 12'd500; on_d = 16'd6; rise_t = 16'd4;
        en = 1'b1;
        adv(2);
        en = 1'b0;
        adv(1);
        chk("R2 abort delay mode", mode, 0);
        adv(9);
        chk("R2 abort delay no ramp", ref_code, 0);
        chk("R2 abort delay stays off", mode, 0);
    endtask

    task automatic t_abort_ramp();
        longint c;
        tgt = 12'd2000; on_d = 16'd1; rise_t = 16'd10; fall_t = 16'd6;
        en = 1'b1;
        adv(3);
        chk("R8 ramp entered", mode, 1);
        adv(3);
        c = 3 * ((longint'(2000) << 16) / 10);
        chk("R8 code before abort", ref_code, c >> 16);
        en = 1'b0;
        adv(1);
        chk("R8 direct to ramp down", mode, 1);
        chk("R8 starts from current", ref_code, c >> 16);
        for (int j = 1; j < 6; j++) begin
            adv(1);
            chk("R8 fall code", ref_code, dn_code(c, 6, j));
        end
        adv(1);
        chk("R8 reaches zero", ref_code, 0);
        chk("R8 idle mode", mode, 0);
        chk("R8 no pgood", pgood, 0);
    endtask

    task automatic t_reenable_ignored();
        rise_seq(300, 0, 2, 1'b0);
        off_d = 16'd3; fall_t = 16'd4;
        en = 1'b0;
        adv(1);
        en = 1'b1;
        adv(3);
        chk("R9 still in off delay", ref_code, 300);
        adv(1);
        chk("R9 ramp down despite enable", mode, 1);
        adv(4);
        chk("R9 reaches zero", ref_code, 0);
        chk("R9 idle mode", mode, 0);
        en = 1'b0;
        adv(2);
        chk("R9 settled idle", mode, 0);
    endtask

    task automatic t_tracking();
        tgt = 12'd900; on_d = 16'd2; rise_t = 16'd50; off_d = 16'd1; fall_t = 16'd50;
        trk_en = 1'b1; trk_code = 12'd0;
        en = 1'b1;
        adv(4);
        chk("R10 ramp entered", mode, 1);
        trk_code = 12'd400;
        adv(1);
        chk("R10 follows other rail", ref_code, 400);
        trk_code = 12'd905;
        adv(1);
        chk("R10 clamped to target", ref_code, 900);
        chk("R10 pgood on reach", pgood, 1);
        chk("R10 regulate mode", mode, 2);
        en = 1'b0;
        adv(3);
        chk("R10 ramp down entered", mode, 1);
        trk_code = 12'd250;
        adv(1);
        chk("R10 follows down", ref_code, 250);
        trk_code = 12'd0;
        adv(1);
        chk("R10 zero ends ramp", ref_code, 0);
        chk("R10 idle mode", mode, 0);
        trk_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_basic_cycle();
        t_target_latched();
        t_zero_rise();
        t_abort_on_delay();
        t_abort_ramp();
        t_reenable_ignored();
        t_tracking();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule